// File: doc/BRIEF.md
# Bit-Serial BCD Time-of-Year Reader

This block lets software fetch the calendar time one bit per register access. A status register exposes a single time bit; every read of that register delivers the next bit of a 64-bit record made of eight packed-BCD bytes. The first read of a sequence freezes the current calendar time from the input ports into the record. The other 63 reads then walk through that frozen copy, so the whole sequence shows one consistent time even if the inputs change partway through.

Software restarts a sequence by writing the register with any value. The calendar time is kept elsewhere and arrives here in binary. The block converts each field to BCD when it takes the snapshot. The record bytes go out in ascending order, and the bits within each byte go out least significant first.

Top module: `tod_serial_reader`

## Requirements
- R1: After a synchronous active-low reset, `bit_o` is 0 and the bit pointer is 0. The first read after reset therefore starts a fresh sequence.
- R2: `bit_o` is registered. It changes only in the clock cycle after an accepted read strobe and holds its value in every other cycle.
- R3: A read accepted while the pointer is 0 captures the calendar inputs into the record. Changes to the inputs during the rest of the sequence do not affect the bits returned. The first bit returned comes from the new capture.
- R4: The record byte order is fixed. Byte 0 is hundredths, always 0x50. Byte 1 is seconds, byte 2 minutes, byte 3 hours, byte 4 day of week, byte 5 day of month, byte 6 month and byte 7 year.
- R5: Each time byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R6: Read number n of a sequence (n = 0..63) returns bit n mod 8 of byte n div 8. Bytes therefore go out in ascending order, least significant bit first within each byte.
- R7: After the 64th read the pointer wraps to 0, so the 65th read captures a new snapshot.
- R8: A write strobe resets the pointer to 0 and does not change `bit_o`. The next read then captures a new snapshot.
- R9: When read and write strobes are asserted in the same cycle, the write takes effect and the read is ignored: the pointer goes to 0 and `bit_o` holds.
- R10: The month input, 0-11, is reported as 1-12. The year byte is the binary year input reduced modulo 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | One-cycle strobe: the status register is read |
| wr_stb | input | 1 | One-cycle strobe: the status register is written |
| sec_i | input | 6 | Seconds, binary 0-59 |
| min_i | input | 6 | Minutes, binary 0-59 |
| hour_i | input | 5 | Hours, binary 0-23 |
| dow_i | input | 3 | Day of week, binary 0-6 |
| dom_i | input | 5 | Day of month, binary 1-31 |
| mon_i | input | 4 | Month, binary 0-11 |
| year_i | input | YEAR_W (16) | Full binary year |
| bit_o | output | 1 | Time bit returned by the last accepted read |

## Verification
A pointer that is off by one shifts every later bit. The error shows up at the next read as a byte that is rotated by one position or a 0x50 byte in the wrong place. A snapshot taken at the wrong moment, or a record that is not held, shows up only when the time inputs change during a sequence. The bench therefore changes the time inputs between reads. It also mixes writes, combined strobes and idle cycles into the random traffic, so that a wrong pointer or a lost snapshot appears at the very next compared bit.

// File: rtl/tod_pkg.sv
// Shared constants for the serial time-of-year reader.
// Assumes a record of whole bytes whose bit count is a power of two.
package tod_pkg;
    localparam int REC_BYTES = 8;
    localparam int BYTE_W    = 8;
    localparam int REC_BITS  = REC_BYTES * BYTE_W;
    localparam int PTR_W     = $clog2(REC_BITS);
    localparam int FIELD_W   = 7;          // binary field width, values 0..99
    localparam logic [BYTE_W-1:0] FILL_CODE = 8'h50;  // constant hundredths byte
endpackage

// File: rtl/tod_bcd_conv.sv
// Converts a binary value below 100 to two packed BCD digits (tens high).
// Assumes the input is in range; larger values give meaningless digits.
module tod_bcd_conv
    import tod_pkg::*;
(
    input  logic [FIELD_W-1:0] bin_i,
    output logic [BYTE_W-1:0]  bcd_o
);
    logic [FIELD_W-1:0] tens;
    logic [FIELD_W-1:0] units;

    // Divide by ten and keep the remainder as the units digit.
    always_comb begin
        tens  = bin_i / FIELD_W'(10);
        units = bin_i - FIELD_W'(tens * FIELD_W'(10));
        bcd_o = {tens[3:0], units[3:0]};
    end
endmodule

// File: rtl/tod_bit_pointer.sv
// Bit pointer over the record: advances on accepted reads, clears on writes,
// wraps to zero after the last bit. Assumes clr has priority over adv.
module tod_bit_pointer
    import tod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr,
    output logic             at_zero
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(REC_BITS - 1);

    // Pointer register with clear, wrap and step.
    always_ff @(posedge clk) begin
        if (!rst_n)            ptr <= '0;
        else if (clr)          ptr <= '0;
        else if (adv) begin
            if (ptr == LAST)   ptr <= '0;
            else               ptr <= ptr + 1'b1;
        end
    end

    assign at_zero = (ptr == '0);

    // R8
    wr_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0));
    // R7
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ptr == LAST) |=> (ptr == '0));
    // R6
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ptr != LAST) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));
    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/tod_snapshot.sv
// Holds the 64-bit BCD time record; loads the fresh image on request only.
// Assumes load is raised only for a read at pointer zero.
module tod_snapshot
    import tod_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [REC_BITS-1:0] fresh,
    output logic [REC_BITS-1:0] rec
);
    // Record register: cleared by reset, replaced on a snapshot.
    always_ff @(posedge clk) begin
        if (!rst_n)     rec <= '0;
        else if (load)  rec <= fresh;
    end

    // R3
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(rec));
    // R4
    fill_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (rec[BYTE_W-1:0] == FILL_CODE));

    for (genvar n = 0; n < REC_BITS / 4; n++) begin : g_nib
        // R5
        nibble_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rec[4*n +: 4] <= 4'd9);
    end
endmodule

// File: rtl/tod_serial_reader.sv
// Serial time-of-year reader: each accepted read returns the next record bit
// on a registered output; a read at pointer zero first snapshots the inputs.
// Assumes binary inputs within calendar ranges and one-cycle strobes.
module tod_serial_reader
    import tod_pkg::*;
#(
    parameter int YEAR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [5:0]        sec_i,
    input  logic [5:0]        min_i,
    input  logic [4:0]        hour_i,
    input  logic [2:0]        dow_i,
    input  logic [4:0]        dom_i,
    input  logic [3:0]        mon_i,
    input  logic [YEAR_W-1:0] year_i,
    output logic              bit_o
);
    localparam int NUM_FIELDS = REC_BYTES - 1;

    logic                rd_take;
    logic                snap;
    logic [PTR_W-1:0]    ptr;
    logic                at_zero;
    logic [REC_BITS-1:0] fresh;
    logic [REC_BITS-1:0] rec;
    logic [YEAR_W-1:0]   yr_mod;
    logic [FIELD_W-1:0]  field_bin [NUM_FIELDS];

    // A write outranks a read in the same cycle.
    assign rd_take = rd_stb && !wr_stb;
    assign snap    = rd_take && at_zero;

    // Binary fields widened to the converter width, month shifted to 1..12.
    always_comb begin
        yr_mod       = year_i % YEAR_W'(100);
        field_bin[0] = FIELD_W'(sec_i);
        field_bin[1] = FIELD_W'(min_i);
        field_bin[2] = FIELD_W'(hour_i);
        field_bin[3] = FIELD_W'(dow_i);
        field_bin[4] = FIELD_W'(dom_i);
        field_bin[5] = FIELD_W'(mon_i) + FIELD_W'(1);
        field_bin[6] = yr_mod[FIELD_W-1:0];
    end

    assign fresh[BYTE_W-1:0] = FILL_CODE;
    for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_conv
        tod_bcd_conv u_conv (
            .bin_i (field_bin[k]),
            .bcd_o (fresh[BYTE_W*(k+1) +: BYTE_W])
        );
    end

    tod_bit_pointer u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (rd_take),
        .clr     (wr_stb),
        .ptr     (ptr),
        .at_zero (at_zero)
    );

    tod_snapshot u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (snap),
        .fresh (fresh),
        .rec   (rec)
    );

    // Output bit register: the new snapshot feeds the first bit directly.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_o <= 1'b0;
        else if (snap)     bit_o <= fresh[0];
        else if (rd_take)  bit_o <= rec[ptr];
    end

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> $stable(bit_o));
    // R9
    both_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && wr_stb) |=> ($stable(bit_o) && at_zero));
    // R3
    snap_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap |=> (bit_o == FILL_CODE[0]));
endmodule

// File: tb/tod_serial_reader_tb_top.sv
module tod_serial_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic [5:0]  sec_i = '0;
    logic [5:0]  min_i = '0;
    logic [4:0]  hour_i = '0;
    logic [2:0]  dow_i = '0;
    logic [4:0]  dom_i = 5'd1;
    logic [3:0]  mon_i = '0;
    logic [15:0] year_i = '0;
    logic        bit_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [63:0] rec_m = '0;
    int          ptr_m = 0;
    logic        exp_bit = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tod_serial_reader dut_i (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .sec_i(sec_i), .min_i(min_i), .hour_i(hour_i), .dow_i(dow_i),
        .dom_i(dom_i), .mon_i(mon_i), .year_i(year_i), .bit_o(bit_o)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [63:0] mk_record(input int s, input int mi, input int h,
        input int dw, input int dm, input int mo, input int y);
        return {to_bcd(y % 100), to_bcd(mo + 1), to_bcd(dm), to_bcd(dw),
                to_bcd(h), to_bcd(mi), to_bcd(s), 8'h50};
    endfunction

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int dw,
        input int dm, input int mo, input int y);
        sec_i = 6'(s); min_i = 6'(mi); hour_i = 5'(h); dow_i = 3'(dw);
        dom_i = 5'(dm); mon_i = 4'(mo); year_i = 16'(y);
    endtask

    // One cycle of traffic, driven at a negedge and checked at the next one.
    task automatic op(input bit rd, input bit wr);
        string tag;
        rd_stb = rd; wr_stb = wr;
        if (wr) begin
            ptr_m = 0;
        end else if (rd) begin
            if (ptr_m == 0)
                rec_m = mk_record(int'(sec_i), int'(min_i), int'(hour_i), int'(dow_i),
                                  int'(dom_i), int'(mon_i), int'(year_i));
            exp_bit = rec_m[ptr_m];
            ptr_m = (ptr_m + 1) % 64;
        end
        @(negedge clk);
        rd_stb = 1'b0; wr_stb = 1'b0;
        tag = wr ? (rd ? "R9" : "R8") : (rd ? "R6" : "R2");
        check(tag, {63'd0, bit_o}, {63'd0, exp_bit});
    endtask

    task automatic read_bytes(input int n, output logic [63:0] got);
        got = '0;
        for (int i = 0; i < n * 8; i++) begin
            op(1'b1, 1'b0);
            got[i] = bit_o;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            report();
        end
    end

    initial begin
        logic [63:0] got;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state of the output
        check("R1", {63'd0, bit_o}, 64'd0);

        // R4 R5 R10 R3: full record with mid-sequence input change
        set_time(59, 7, 23, 6, 31, 11, 1999);
        read_bytes(2, got);
        check("R4", got[15:0], 16'h5950);
        set_time(3, 44, 1, 2, 9, 4, 2024);   // must not leak into this sequence
        got = '0;
        for (int i = 16; i < 64; i++) begin op(1'b1, 1'b0); got[i] = bit_o; end
        check("R3", got[63:16], 48'h9912_3106_2307);
        check("R10", {56'd0, got[55:48]}, 64'h12);

        // R7: wrap takes a fresh snapshot
        read_bytes(2, got);
        check("R7", got[15:0], 16'h0350);

        // R2: idle cycles hold the output
        repeat (3) op(1'b0, 1'b0);

        // R8: write mid-sequence restarts
        repeat (5) op(1'b1, 1'b0);
        set_time(42, 0, 12, 0, 1, 0, 2100);
        op(1'b0, 1'b1);
        read_bytes(8, got);
        check("R8", got, 64'h0001_0100_1200_4250);
        check("R10", {56'd0, got[63:56]}, 64'h00);

        // R9: combined strobes behave as a write
        repeat (9) op(1'b1, 1'b0);
        set_time(17, 5, 8, 3, 20, 9, 1987);
        op(1'b1, 1'b1);
        read_bytes(2, got);
        check("R9", got[15:0], 16'h1750);

        // R6: random traffic with changing time
        for (int i = 0; i < 4000; i++) begin
            int r = $urandom_range(99);
            if ($urandom_range(9) == 0)
                set_time($urandom_range(59), $urandom_range(59), $urandom_range(23),
                         $urandom_range(6), $urandom_range(31, 1), $urandom_range(11),
                         $urandom_range(65535));
            if (r < 80)      op(1'b1, 1'b0);
            else if (r < 88) op(1'b0, 1'b0);
            else if (r < 96) op(1'b0, 1'b1);
            else             op(1'b1, 1'b1);
        end

        done = 1'b1;
        report();
    end
endmodule